// File: doc/BRIEF.md
# Interrupt Pending and Gating Controller

This block keeps the pending interrupt state of a small processor core. Eight interrupt levels are held as one bit each in a pending vector. Other logic can post a level, clear a level, or wipe the whole vector. A count/compare timer-match detector can also set a pending bit, at a level chosen by a 3-bit selector.

From the pending vector and the core's status inputs the block makes two outputs. The first is a registered interrupt request for the pipeline. It is raised only when three conditions hold:
- the global enable is set;
- the core is neither at error level nor at exception level;
- at least one pending bit is also enabled by the 8-bit level mask.

The second output is a flag that shows whether any level is pending. The pending vector itself is also driven out so that it can be read back.

All requests made in one cycle are merged into a single update of the register.

Top module: `irq_pend_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first rising edge of `clk` after it is released, `pend_vec` is 0, `irq_req` is 0 and `any_pend` is 0.
- R2: When `post_vld` is high, the rising edge of `clk` sets bit `post_lvl` of `pend_vec`, where bit n stands for level n. All other bits keep their values.
- R3: When `clr_vld` is high, the rising edge of `clk` clears bit `clr_lvl` of `pend_vec`. All other bits keep their values.
- R4: When `clr_all` is high, the rising edge of `clk` writes 0 to all of `pend_vec`. This overrides any post, clear or timer set in the same cycle.
- R5: If a post or a timer set names the same bit as a clear in the same cycle, that bit ends up set.
- R6: A timer match occurs when `tmr_count` equals `tmr_compare` and `tmr_count` is not zero. On a timer match, the rising edge of `clk` sets bit `tmr_lvl` of `pend_vec`. Without a timer match, the timer sets no bit.
- R7: `any_pend` is high exactly when `pend_vec`, which already includes the latest timer update, is not zero.
- R8: `irq_req` goes high only when all of these held in the previous cycle: `glb_en` was 1, `err_lvl` was 0, `exc_lvl` was 0, and `lvl_mask & pend_vec` was not zero. Otherwise `irq_req` is 0.
- R9: `irq_req` is registered. It reflects a change of the pending vector, the mask or the status inputs one clock after that change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| post_vld | input | 1 | Post request |
| post_lvl | input | 3 | Level to post |
| clr_vld | input | 1 | Clear request |
| clr_lvl | input | 3 | Level to clear |
| clr_all | input | 1 | Clear the whole pending vector |
| glb_en | input | 1 | Global interrupt enable |
| err_lvl | input | 1 | Core is at error level |
| exc_lvl | input | 1 | Core is at exception level |
| lvl_mask | input | 8 | Per-level enable mask |
| tmr_count | input | 32 | Timer count value |
| tmr_compare | input | 32 | Timer compare value |
| tmr_lvl | input | 3 | Level that a timer match sets |
| irq_req | output | 1 | Registered interrupt request |
| any_pend | output | 1 | Any level pending |
| pend_vec | output | 8 | Pending vector readback |

## Verification
Posting, clearing and timer matching can all fall in the same cycle. The stimulus table drives them together on purpose:
- a post and a clear of the same level;
- a timer match on a level that is being cleared;
- a clear-all that coincides with both a post and a timer match.

After each of these the bench reads the pending vector on the following cycle and compares it with the merge rule: clear-all wins over everything, and otherwise sets win over clears. Timer matches with a zero count, or with count and compare unequal, are mixed into the same table to show that they set nothing.

// File: rtl/irq_pend_pkg.sv
// Package: shared sizes for the interrupt pending controller.
// Assumes the level count is a power of two, so that a level index field
// can never point outside the pending vector.
package irq_pend_pkg;
    localparam int unsigned NUM_LVL   = 8;
    localparam int unsigned LVL_IDX_W = $clog2(NUM_LVL);
    localparam int unsigned CNT_W     = 32;
endpackage

// File: rtl/irq_lvl_dec.sv
// Module: level decoder. Turns a qualified level index into a one-hot mask.
// Assumes N_LVL == 2**IDX_W.
module irq_lvl_dec #(
    parameter int unsigned N_LVL = 8,
    parameter int unsigned IDX_W = 3
) (
    input  logic             vld,
    input  logic [IDX_W-1:0] idx,
    output logic [N_LVL-1:0] onehot
);
    // One comparator per level; output bit n is set only when idx names level n.
    for (genvar n = 0; n < N_LVL; n++) begin : g_bit
        assign onehot[n] = vld && (idx == IDX_W'(n));
    end
endmodule

// File: rtl/irq_tmr_match.sv
// Module: timer match detector. Flags count == compare with a nonzero count.
// Assumes count and compare are stable around the clock edge.
module irq_tmr_match #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] count,
    input  logic [W-1:0] compare,
    output logic         hit
);
    // Equality gated by a nonzero count.
    always_comb hit = (count == compare) && (count != '0);
endmodule

// File: rtl/irq_pend_reg.sv
// Module: pending vector register. Merges the set, clear and wipe requests
// into one update. Priority: wipe first, then sets, then clears.
module irq_pend_reg #(
    parameter int unsigned N_LVL = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_LVL-1:0] set_msk,
    input  logic [N_LVL-1:0] clr_msk,
    input  logic             wipe,
    output logic [N_LVL-1:0] pend_q
);
    // One flop per level, each with its own merge of the requests.
    for (genvar n = 0; n < N_LVL; n++) begin : g_flop
        always_ff @(posedge clk) begin
            if (!rst_n || wipe) pend_q[n] <= 1'b0;
            else if (set_msk[n]) pend_q[n] <= 1'b1;
            else if (clr_msk[n]) pend_q[n] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_gate.sv
// Module: interrupt gate. Registers the request from the status and the
// masked pending bits. Assumes the status inputs are synchronous to clk.
module irq_gate #(
    parameter int unsigned N_LVL = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glb_en,
    input  logic             err_lvl,
    input  logic             exc_lvl,
    input  logic [N_LVL-1:0] mask,
    input  logic [N_LVL-1:0] pend,
    output logic             irq_q
);
    logic allow;
    logic hit;

    // The status qualifies: enabled, and at neither error nor exception level.
    always_comb allow = glb_en && !err_lvl && !exc_lvl;
    // At least one pending bit is also unmasked.
    always_comb hit = |(mask & pend);

    // Registered request toward the pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= allow && hit;
    end
endmodule

// File: rtl/irq_pend_ctrl.sv
// Module: interrupt pending and gating controller (top).
// Collects the post, clear, clear-all and timer-match requests into the
// pending vector, then gates it into a registered interrupt request.
// Assumes all inputs are synchronous to clk.
module irq_pend_ctrl
    import irq_pend_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 post_vld,
    input  logic [LVL_IDX_W-1:0] post_lvl,
    input  logic                 clr_vld,
    input  logic [LVL_IDX_W-1:0] clr_lvl,
    input  logic                 clr_all,
    input  logic                 glb_en,
    input  logic                 err_lvl,
    input  logic                 exc_lvl,
    input  logic [NUM_LVL-1:0]   lvl_mask,
    input  logic [CNT_W-1:0]     tmr_count,
    input  logic [CNT_W-1:0]     tmr_compare,
    input  logic [LVL_IDX_W-1:0] tmr_lvl,
    output logic                 irq_req,
    output logic                 any_pend,
    output logic [NUM_LVL-1:0]   pend_vec
);
    logic [NUM_LVL-1:0] post_oh;
    logic [NUM_LVL-1:0] tmr_oh;
    logic [NUM_LVL-1:0] clr_oh;
    logic [NUM_LVL-1:0] set_all;
    logic               tmr_hit;

    irq_tmr_match #(.W(CNT_W)) u_tmr (
        .count(tmr_count), .compare(tmr_compare), .hit(tmr_hit)
    );

    irq_lvl_dec #(.N_LVL(NUM_LVL), .IDX_W(LVL_IDX_W)) u_dec_post (
        .vld(post_vld), .idx(post_lvl), .onehot(post_oh)
    );
    irq_lvl_dec #(.N_LVL(NUM_LVL), .IDX_W(LVL_IDX_W)) u_dec_tmr (
        .vld(tmr_hit), .idx(tmr_lvl), .onehot(tmr_oh)
    );
    irq_lvl_dec #(.N_LVL(NUM_LVL), .IDX_W(LVL_IDX_W)) u_dec_clr (
        .vld(clr_vld), .idx(clr_lvl), .onehot(clr_oh)
    );

    // Posted levels and timer levels form one combined set mask.
    always_comb set_all = post_oh | tmr_oh;

    irq_pend_reg #(.N_LVL(NUM_LVL)) u_reg (
        .clk(clk), .rst_n(rst_n), .set_msk(set_all), .clr_msk(clr_oh),
        .wipe(clr_all), .pend_q(pend_vec)
    );

    irq_gate #(.N_LVL(NUM_LVL)) u_gate (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .err_lvl(err_lvl),
        .exc_lvl(exc_lvl), .mask(lvl_mask), .pend(pend_vec), .irq_q(irq_req)
    );

    // The pending flag is taken from the registered vector, which already
    // includes the latest timer update.
    always_comb any_pend = |pend_vec;
endmodule

// File: rtl/irq_pend_chk.sv
// Module: assertion checker for irq_pend_ctrl, attached to it by bind.
module irq_pend_chk
    import irq_pend_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 post_vld,
    input logic [LVL_IDX_W-1:0] post_lvl,
    input logic                 clr_vld,
    input logic [LVL_IDX_W-1:0] clr_lvl,
    input logic                 clr_all,
    input logic                 glb_en,
    input logic                 err_lvl,
    input logic                 exc_lvl,
    input logic [NUM_LVL-1:0]   lvl_mask,
    input logic [CNT_W-1:0]     tmr_count,
    input logic [CNT_W-1:0]     tmr_compare,
    input logic [LVL_IDX_W-1:0] tmr_lvl,
    input logic                 irq_req,
    input logic                 any_pend,
    input logic [NUM_LVL-1:0]   pend_vec
);
    assert_wipe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (pend_vec == '0));

    assert_post_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (post_vld && !clr_all) |=> pend_vec[$past(post_lvl)]);

    assert_setwins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (post_vld && clr_vld && post_lvl == clr_lvl && !clr_all)
        |=> pend_vec[$past(clr_lvl)]);

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vld && !clr_all && !(post_vld && post_lvl == clr_lvl)
         && !(tmr_count == tmr_compare && tmr_count != '0 && tmr_lvl == clr_lvl))
        |=> !pend_vec[$past(clr_lvl)]);

    assert_timer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_count == tmr_compare && tmr_count != '0 && !clr_all)
        |=> pend_vec[$past(tmr_lvl)]);

    assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(glb_en && !err_lvl && !exc_lvl && (|(lvl_mask & pend_vec))));

    assert_pendflag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(any_pend));
endmodule

bind irq_pend_ctrl irq_pend_chk chk_i (.*);

// File: tb/irq_pend_ctrl_tb_top.sv
module irq_pend_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        post_vld, clr_vld, clr_all, glb_en, err_lvl, exc_lvl;
    logic [2:0]  post_lvl, clr_lvl, tmr_lvl;
    logic [7:0]  lvl_mask;
    logic [31:0] tmr_count, tmr_compare;
    logic        irq_req, any_pend;
    logic [7:0]  pend_vec;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    irq_pend_ctrl dut_i (.*);

    typedef struct packed {
        logic       pv; logic [2:0] pl;
        logic       cv; logic [2:0] cl;
        logic       ca;
        logic [7:0] cnt; logic [7:0] cmp; logic [2:0] tl;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [0:NV-1] = '{
        '{1'b1,3'd3, 1'b0,3'd0, 1'b0, 8'd0,8'd1,3'd0, 8'h08}, // R2 post 3
        '{1'b1,3'd0, 1'b0,3'd0, 1'b0, 8'd0,8'd1,3'd0, 8'h09}, // R2 post 0
        '{1'b0,3'd0, 1'b1,3'd3, 1'b0, 8'd0,8'd1,3'd0, 8'h01}, // R3 clear 3
        '{1'b1,3'd5, 1'b1,3'd5, 1'b0, 8'd0,8'd1,3'd0, 8'h21}, // R5 post+clear 5
        '{1'b0,3'd0, 1'b0,3'd0, 1'b0, 8'd7,8'd7,3'd6, 8'h61}, // R6 match lvl 6
        '{1'b0,3'd0, 1'b0,3'd0, 1'b0, 8'd0,8'd0,3'd1, 8'h61}, // R6 zero count
        '{1'b0,3'd0, 1'b0,3'd0, 1'b0, 8'd5,8'd6,3'd1, 8'h61}, // R6 unequal
        '{1'b1,3'd2, 1'b0,3'd0, 1'b1, 8'd4,8'd4,3'd7, 8'h00}, // R4 wipe wins
        '{1'b1,3'd7, 1'b0,3'd0, 1'b0, 8'd9,8'd9,3'd2, 8'h84}, // R2/R6 together
        '{1'b0,3'd0, 1'b1,3'd7, 1'b0, 8'd3,8'd3,3'd7, 8'h84}, // R5 timer vs clear
        '{1'b0,3'd0, 1'b1,3'd2, 1'b0, 8'd0,8'd1,3'd0, 8'h80}, // R3 clear 2
        '{1'b1,3'd1, 1'b1,3'd4, 1'b0, 8'd0,8'd1,3'd0, 8'h82}  // R2/R3 distinct
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        post_vld = 0; clr_vld = 0; clr_all = 0;
        tmr_count = 0; tmr_compare = 1;
    endtask

    initial begin
        rst_n = 0; idle(); post_lvl = 0; clr_lvl = 0; tmr_lvl = 0;
        glb_en = 0; err_lvl = 0; exc_lvl = 0; lvl_mask = 0;
        repeat (3) @(negedge clk);
        chk("R1 pend", 32'(pend_vec), 0);
        chk("R1 irq", 32'(irq_req), 0);
        chk("R1 any", 32'(any_pend), 0);
        rst_n = 1;
        @(negedge clk);

        // Table walk: one request cycle, then check the following cycle.
        for (int i = 0; i < NV; i++) begin
            post_vld = TBL[i].pv; post_lvl = TBL[i].pl;
            clr_vld  = TBL[i].cv; clr_lvl  = TBL[i].cl;
            clr_all  = TBL[i].ca;
            tmr_count = 32'(TBL[i].cnt); tmr_compare = 32'(TBL[i].cmp);
            tmr_lvl  = TBL[i].tl;
            @(negedge clk);
            idle();
            chk($sformatf("R2-6 vec %0d", i), 32'(pend_vec), 32'(TBL[i].exp));
            chk($sformatf("R7 vec %0d", i), 32'(any_pend), 32'(TBL[i].exp != 0));
        end

        // Gating: pend = 0x82 here.
        glb_en = 1; lvl_mask = 8'h00;
        @(negedge clk); @(negedge clk);
        chk("R8 masked", 32'(irq_req), 0);
        lvl_mask = 8'h02;
        #1 chk("R9 not yet", 32'(irq_req), 0);
        @(negedge clk);
        chk("R9 after one clock", 32'(irq_req), 1);
        chk("R8 enabled", 32'(irq_req), 1);
        err_lvl = 1; @(negedge clk);
        chk("R8 err", 32'(irq_req), 0);
        err_lvl = 0; exc_lvl = 1; @(negedge clk);
        chk("R8 exc", 32'(irq_req), 0);
        exc_lvl = 0; glb_en = 0; @(negedge clk);
        chk("R8 glb", 32'(irq_req), 0);
        glb_en = 1; @(negedge clk);
        chk("R8 restore", 32'(irq_req), 1);
        clr_vld = 1; clr_lvl = 1; @(negedge clk); idle();
        chk("R3 clear 1", 32'(pend_vec), 32'h80);
        @(negedge clk);
        chk("R9 irq drops", 32'(irq_req), 0);

        // Reset in the middle of a run.
        post_vld = 1; post_lvl = 7; rst_n = 0; @(negedge clk); idle();
        chk("R1 mid pend", 32'(pend_vec), 0);
        chk("R1 mid irq", 32'(irq_req), 0);
        chk("R1 mid any", 32'(any_pend), 0);
        rst_n = 1; @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule